// File: doc/BRIEF.md
# Group-Address Hash Filter

This block decides whether a received frame's destination MAC address passes a 256-bin hash filter for group (multicast) addresses. The receive path presents the 48-bit destination address together with a one-cycle strobe. The block then runs a CRC-32 over the six address bytes, one byte per clock. It forms an 8-bit bin number from the bit-reversed CRC and looks that bin up in a 256-bit table. A few cycles later it reports whether the frame is accepted.

Software loads the table in two ways. It can write whole 32-bit words, of which there are eight. It can also set or clear a single bin by giving its number. Every word can be read back through a registered read port. After reset the table is empty, so no group address passes until bins are set. The bin number of each lookup is also brought out, which lets the filter software compute where an address lands.

Top module: `mcast_hash_filter`

## Requirements
- R1: The bin number on `res_bin` is the top 8 bits of the bit-reversed CRC-32 of the address. The CRC uses polynomial 0x04C11DB7, a preset of all ones and no final inversion. Bytes are taken from `dest_addr[47:40]` down to `dest_addr[7:0]`, and each byte is fed least significant bit first.
- R2: `res_valid` is high for exactly one cycle. That cycle starts at the sixth rising edge after the edge that samples `addr_strobe` high.
- R3: `res_accept` is 1 only while `res_valid` is high, the group bit `dest_addr[40]` is 1 and the selected table bit is 1. In every other case it is 0.
- R4: Bin b lives in table word b[7:5], at bit position 31 − b[4:0]. So bin 0 is bit 31 of word 0 and bin 255 is bit 0 of word 7.
- R5: Reset clears all eight table words, `tbl_rd_data`, `res_valid`, `res_accept` and `res_bin` to zero.
- R6: A word write with `tbl_wr_en` replaces the word chosen by `tbl_wr_sel`. `tbl_rd_data` shows the word chosen by `tbl_rd_sel`, registered, one edge after the selection.
- R7: A bin command with `bin_cmd_en` writes `bin_cmd_set` into the single bit named by `bin_cmd_idx` and leaves all other table bits unchanged.
- R8: If a word write and a bin command target the same word in the same cycle, the word is first replaced and the bin command then decides its own bit.
- R9: A strobe that arrives while a CRC is still in progress abandons the earlier address. Only one result appears, for the newer address, timed from the newer strobe.
- R10: `res_bin` holds its value between results. It changes only in a cycle in which `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Destination address valid for one cycle |
| dest_addr | input | 48 | Destination address, first byte in bits 47:40 |
| tbl_wr_en | input | 1 | Word write enable |
| tbl_wr_sel | input | 3 | Word number for write |
| tbl_wr_data | input | 32 | Word write data |
| tbl_rd_sel | input | 3 | Word number for readback |
| tbl_rd_data | output | 32 | Registered readback word |
| bin_cmd_en | input | 1 | Single-bin command enable |
| bin_cmd_idx | input | 8 | Bin number to modify |
| bin_cmd_set | input | 1 | 1 sets the bin, 0 clears it |
| res_valid | output | 1 | Result valid pulse |
| res_accept | output | 1 | Address accepted |
| res_bin | output | 8 | Bin number of the last lookup |

## Verification
The hardest case to reach from the ports is a lookup that lands on a chosen bin. The CRC scrambles the address, so no hand-picked address hits a known bin. The bench therefore computes each address's bin with its own right-shifting reflected CRC model and sets exactly that bin before presenting the address. It then repeats the address with the table cleared, and once more with only the group bit flipped. A second strobe is issued two cycles into a computation to reach the restart case, and the bench counts the result pulses that follow.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam int          CRC_W    = 32;

  // Advance a left-shifting CRC by one byte, data taken LSB first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ADDR_BYTES*8-1:0] addr,
  output logic                    crc_valid,
  output logic [CRC_W-1:0]        crc_out,
  output logic                    grp_bit
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int REST_W = ADDR_W - 8;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

  logic              busy;
  logic [CNT_W-1:0]  left;
  logic [REST_W-1:0] rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      left      <= '0;
      rest      <= '0;
      crc_out   <= '1;
      grp_bit   <= 1'b0;
      crc_valid <= 1'b0;
    end else begin
      crc_valid <= 1'b0;
      if (start) begin
        crc_out <= crc_step_byte('1, addr[ADDR_W-1 -: 8]);
        rest    <= addr[REST_W-1:0];
        grp_bit <= addr[ADDR_W-8];
        left    <= CNT_W'(ADDR_BYTES - 1);
        busy    <= 1'b1;
      end else if (busy) begin
        crc_out <= crc_step_byte(crc_out, rest[REST_W-1 -: 8]);
        rest    <= {rest[REST_W-9:0], 8'h00};
        left    <= left - 1'b1;
        if (left == CNT_W'(1)) begin
          busy      <= 1'b0;
          crc_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int TBL_WORDS = 8,
  parameter int WORD_W    = 32
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [$clog2(TBL_WORDS)-1:0]              wr_sel,
  input  logic [WORD_W-1:0]                         wr_data,
  input  logic [$clog2(TBL_WORDS)-1:0]              rd_sel,
  output logic [WORD_W-1:0]                         rd_data,
  input  logic                                      bin_en,
  input  logic [$clog2(TBL_WORDS*WORD_W)-1:0]       bin_idx,
  input  logic                                      bin_set,
  input  logic [$clog2(TBL_WORDS*WORD_W)-1:0]       look_idx,
  output logic                                      look_bit
);
  localparam int SEL_W = $clog2(TBL_WORDS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = SEL_W + BIT_W;

  logic [WORD_W-1:0] words    [TBL_WORDS];
  logic [WORD_W-1:0] words_nx [TBL_WORDS];

  logic [SEL_W-1:0] bin_word;
  logic [BIT_W-1:0] bin_pos;
  logic [SEL_W-1:0] look_word;
  logic [BIT_W-1:0] look_pos;

  // MSB-first numbering inside a word: bin n sits at position WORD_W-1-n.
  assign bin_word  = bin_idx[IDX_W-1:BIT_W];
  assign bin_pos   = BIT_W'(WORD_W - 1) - bin_idx[BIT_W-1:0];
  assign look_word = look_idx[IDX_W-1:BIT_W];
  assign look_pos  = BIT_W'(WORD_W - 1) - look_idx[BIT_W-1:0];

  always_comb begin
    for (int w = 0; w < TBL_WORDS; w++) begin
      words_nx[w] = words[w];
      if (wr_en && wr_sel == SEL_W'(w)) words_nx[w] = wr_data;
      if (bin_en && bin_word == SEL_W'(w)) words_nx[w][bin_pos] = bin_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < TBL_WORDS; w++) words[w] <= '0;
      rd_data <= '0;
    end else begin
      for (int w = 0; w < TBL_WORDS; w++) words[w] <= words_nx[w];
      rd_data <= words[rd_sel];
    end
  end

  assign look_bit = words[look_word][look_pos];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc_valid,
  input  logic [CRC_W-1:0] crc,
  input  logic             grp_bit,
  output logic [IDX_W-1:0] look_idx,
  input  logic             look_bit,
  output logic             res_valid,
  output logic             res_accept,
  output logic [IDX_W-1:0] res_bin
);
  logic [CRC_W-1:0] crc_rev;

  assign crc_rev  = bit_reverse(crc);
  assign look_idx = crc_rev[CRC_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_bin    <= '0;
    end else begin
      res_valid  <= crc_valid;
      res_accept <= crc_valid & grp_bit & look_bit;
      if (crc_valid) res_bin <= look_idx;
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int TBL_WORDS  = 8,
  parameter int WORD_W     = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                addr_strobe,
  input  logic [ADDR_BYTES*8-1:0]             dest_addr,
  input  logic                                tbl_wr_en,
  input  logic [$clog2(TBL_WORDS)-1:0]        tbl_wr_sel,
  input  logic [WORD_W-1:0]                   tbl_wr_data,
  input  logic [$clog2(TBL_WORDS)-1:0]        tbl_rd_sel,
  output logic [WORD_W-1:0]                   tbl_rd_data,
  input  logic                                bin_cmd_en,
  input  logic [$clog2(TBL_WORDS*WORD_W)-1:0] bin_cmd_idx,
  input  logic                                bin_cmd_set,
  output logic                                res_valid,
  output logic                                res_accept,
  output logic [$clog2(TBL_WORDS*WORD_W)-1:0] res_bin
);
  localparam int IDX_W = $clog2(TBL_WORDS * WORD_W);

  logic             crc_valid;
  logic [CRC_W-1:0] crc_val;
  logic             grp_bit;
  logic [IDX_W-1:0] look_idx;
  logic             look_bit;

  mhf_crc_engine #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk       (clk),
    .rst       (rst),
    .start     (addr_strobe),
    .addr      (dest_addr),
    .crc_valid (crc_valid),
    .crc_out   (crc_val),
    .grp_bit   (grp_bit)
  );

  mhf_table #(.TBL_WORDS(TBL_WORDS), .WORD_W(WORD_W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_wr_en),
    .wr_sel   (tbl_wr_sel),
    .wr_data  (tbl_wr_data),
    .rd_sel   (tbl_rd_sel),
    .rd_data  (tbl_rd_data),
    .bin_en   (bin_cmd_en),
    .bin_idx  (bin_cmd_idx),
    .bin_set  (bin_cmd_set),
    .look_idx (look_idx),
    .look_bit (look_bit)
  );

  mhf_decide #(.IDX_W(IDX_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .crc_valid  (crc_valid),
    .crc        (crc_val),
    .grp_bit    (grp_bit),
    .look_idx   (look_idx),
    .look_bit   (look_bit),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_bin    (res_bin)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_strobe,
  input logic [ADDR_W-1:0] dest_addr,
  input logic [WORD_W-1:0] tbl_rd_data,
  input logic              res_valid,
  input logic              res_accept,
  input logic [IDX_W-1:0]  res_bin
);
  // R2: result pulse lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R2: result follows a strobe six edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(addr_strobe, 7));

  // R3: accept needs a valid result from a group address
  a_r3_accept_valid: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> res_valid);

  a_r3_group_bit: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> $past(dest_addr[ADDR_W-8], 7));

  // R5: readback is zero on the first edge after reset
  a_r5_reset_read: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> tbl_rd_data == '0);

  // R10: bin number holds between results
  a_r10_bin_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_bin));
endmodule

bind mcast_hash_filter mhf_checker #(
  .ADDR_W(ADDR_BYTES * 8), .WORD_W(WORD_W), .IDX_W($clog2(TBL_WORDS * WORD_W))
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_strobe (addr_strobe),
  .dest_addr   (dest_addr),
  .tbl_rd_data (tbl_rd_data),
  .res_valid   (res_valid),
  .res_accept  (res_accept),
  .res_bin     (res_bin)
);

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        addr_strobe;
  logic [47:0] dest_addr;
  logic        tbl_wr_en;
  logic [2:0]  tbl_wr_sel;
  logic [31:0] tbl_wr_data;
  logic [2:0]  tbl_rd_sel;
  logic [31:0] tbl_rd_data;
  logic        bin_cmd_en;
  logic [7:0]  bin_cmd_idx;
  logic        bin_cmd_set;
  logic        res_valid;
  logic        res_accept;
  logic [7:0]  res_bin;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mcast_hash_filter dut (.*);

  // {address, set-bin flag}
  localparam logic [48:0] VEC [0:7] = '{
    {48'h01005E000001, 1'b1},
    {48'h01005E7F1234, 1'b0},
    {48'h333300000016, 1'b1},
    {48'hFFFFFFFFFFFF, 1'b1},
    {48'h001122334455, 1'b1},
    {48'h0180C2000000, 1'b1},
    {48'h030000000001, 1'b0},
    {48'hAB0123456789, 1'b1}
  };

  // Reflected (right-shifting) CRC model; its top byte is the bin.
  function automatic logic [7:0] ref_bin(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    c = '1;
    for (int k = 0; k < 6; k++) begin
      b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    return c[31:24];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); tbl_wr_en = 1; tbl_wr_sel = s; tbl_wr_data = d;
    @(negedge clk); tbl_wr_en = 0;
  endtask

  task automatic bin_cmd(input logic [7:0] idx, input logic set);
    @(negedge clk); bin_cmd_en = 1; bin_cmd_idx = idx; bin_cmd_set = set;
    @(negedge clk); bin_cmd_en = 0;
  endtask

  task automatic read_word(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); tbl_rd_sel = s;
    @(negedge clk); d = tbl_rd_data;
  endtask

  task automatic clear_table();
    for (int w = 0; w < 8; w++) write_word(3'(w), 32'h0);
  endtask

  // Strobe an address; return outputs in the result cycle.
  task automatic lookup(input logic [47:0] a, output logic v, output logic acc,
                        output logic [7:0] bn, output logic early);
    @(negedge clk); addr_strobe = 1; dest_addr = a;
    @(negedge clk); addr_strobe = 0;
    repeat (5) @(negedge clk);
    early = res_valid;
    @(negedge clk);
    v = res_valid; acc = res_accept; bn = res_bin;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic v, acc, early;
    logic [7:0] bn;
    logic [47:0] a;
    int pulses;

    rst = 1; addr_strobe = 0; dest_addr = '0; tbl_wr_en = 0; tbl_wr_sel = 0;
    tbl_wr_data = 0; tbl_rd_sel = 0; bin_cmd_en = 0; bin_cmd_idx = 0; bin_cmd_set = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R5: reset state
    check("R5 res_valid", 32'(res_valid), 0);
    check("R5 res_accept", 32'(res_accept), 0);
    check("R5 res_bin", 32'(res_bin), 0);
    for (int w = 0; w < 8; w++) begin
      read_word(3'(w), rd);
      check("R5 table word", rd, 0);
    end
    // R5: group address rejected on the empty table
    lookup(48'h01005E000001, v, acc, bn, early);
    check("R5 empty table rejects", 32'(acc), 0);

    // Vector walk: R1, R2, R3
    for (int n = 0; n < 8; n++) begin
      a = VEC[n][48:1];
      clear_table();
      if (VEC[n][0]) bin_cmd(ref_bin(a), 1'b1);
      lookup(a, v, acc, bn, early);
      check("R2 no early result", 32'(early), 0);
      check("R2 result valid", 32'(v), 1);
      check("R1 bin number", 32'(bn), 32'(ref_bin(a)));
      check("R3 accept", 32'(acc), 32'(VEC[n][0] & a[40]));
      @(negedge clk);
      check("R2 single pulse", 32'(res_valid), 0);
      check("R3 accept low when idle", 32'(res_accept), 0);
    end

    // R3: same bin set, group bit cleared -> reject (flip bit 40)
    a = 48'h01005E000001;
    clear_table();
    bin_cmd(ref_bin(a), 1'b1);
    lookup(a, v, acc, bn, early);
    check("R3 group accepted", 32'(acc), 1);
    bin_cmd(ref_bin(a ^ 48'h010000000000), 1'b1);
    lookup(a ^ 48'h010000000000, v, acc, bn, early);
    check("R3 unicast rejected", 32'(acc), 0);

    // R4 / R7: bin mapping at corners
    clear_table();
    bin_cmd(8'd0, 1'b1);
    read_word(3'd0, rd); check("R4 bin 0", rd, 32'h80000000);
    bin_cmd(8'd255, 1'b1);
    read_word(3'd7, rd); check("R4 bin 255", rd, 32'h00000001);
    bin_cmd(8'd37, 1'b1);
    read_word(3'd1, rd); check("R4 bin 37", rd, 32'h04000000);
    // R7: clear one bit only
    write_word(3'd2, 32'hFFFFFFFF);
    bin_cmd(8'd70, 1'b0);
    read_word(3'd2, rd); check("R7 clear bin 70", rd, 32'hFDFFFFFF);
    read_word(3'd0, rd); check("R7 other word untouched", rd, 32'h80000000);

    // R6: word write and readback
    write_word(3'd5, 32'hA5C3_0F11);
    read_word(3'd5, rd); check("R6 readback", rd, 32'hA5C30F11);

    // R8: same-cycle word write and bin command
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_sel = 3'd3; tbl_wr_data = 32'h0;
    bin_cmd_en = 1; bin_cmd_idx = 8'd96; bin_cmd_set = 1;
    @(negedge clk); tbl_wr_en = 0; bin_cmd_en = 0;
    read_word(3'd3, rd); check("R8 set wins", rd, 32'h80000000);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_sel = 3'd3; tbl_wr_data = 32'hFFFFFFFF;
    bin_cmd_en = 1; bin_cmd_idx = 8'd97; bin_cmd_set = 0;
    @(negedge clk); tbl_wr_en = 0; bin_cmd_en = 0;
    read_word(3'd3, rd); check("R8 clear wins", rd, 32'hBFFFFFFF);

    // R9: restart two cycles into a computation
    clear_table();
    bin_cmd(ref_bin(48'h333300000016), 1'b1);
    @(negedge clk); addr_strobe = 1; dest_addr = 48'h01005E7F1234;
    @(negedge clk); addr_strobe = 0;
    @(negedge clk);
    @(negedge clk); addr_strobe = 1; dest_addr = 48'h333300000016;
    @(negedge clk); addr_strobe = 0;
    pulses = 0; bn = 0; acc = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (res_valid) begin
        pulses++;
        bn = res_bin; acc = res_accept;
        check("R9 timed from newer strobe", 32'(c), 6);
      end
    end
    check("R9 one result", 32'(pulses), 1);
    check("R9 newer bin", 32'(bn), 32'(ref_bin(48'h333300000016)));
    check("R9 newer accepted", 32'(acc), 1);

    // R10: bin holds while idle
    repeat (4) @(negedge clk);
    check("R10 bin held", 32'(res_bin), 32'(ref_bin(48'h333300000016)));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule